// File: doc/BRIEF.md
# Display-Window Scanout Address Generator

This block produces the stream of 32-bit word addresses used to fetch pixel data from video memory while the display window is active. At every window start it captures a snapshot of its programming: two field base addresses and one packed window-size word, which holds the words per line, the lines per field and a line modulo. The timing generator then sends one line-start strobe per visible line. For each strobe the block emits one address per clock until the programmed row width has been covered. The first address of the next line is the last address of the previous line plus the modulo.

A modulo of 1 makes the lines contiguous. An interlaced field sets the modulo to 1 plus one full line length in words, so each field steps over the lines of the other field. In interlaced operation the block alternates between the two bases on successive windows. It starts on the long-field base after reset, and again after any progressive window. The short-field base is normally the long-field base plus one visible line length.

The controller is a three-state machine:
- ST_IDLE: outside the window.
- ST_WAIT: inside the window, between lines.
- ST_FETCH: emitting addresses.

The transitions are:
- IDLE→WAIT on a window start.
- WAIT→FETCH on a line start.
- FETCH→WAIT at the end of a line while more lines remain.
- FETCH→IDLE at the end of the last line.
- Any state→WAIT on a window start, which aborts a line in progress.

Top module: `scan_addr_gen`

## Requirements
- R1: While reset is held, and after its release until the first window start, fetch_valid is 0 and line starts produce no addresses.
- R2: win_size packs the row width in words minus one in bits [9:0], the line count minus one in bits [19:10] and the line modulo in bits [29:20]. Each line yields exactly width+1 valid addresses, and each window yields exactly count+1 lines.
- R3: A line-start strobe sampled at a clock edge makes fetch_valid 1 from that edge on. The address then rises by exactly 1 on every following clock until the line ends, after which fetch_valid returns to 0.
- R4: The first address of each line after the first equals the last address of the previous line plus the modulo.
- R5: The first address of the first line in a window equals the base captured at that window start.
- R6: After the last programmed line of a window, further line starts produce no valid address until the next window start.
- R7: Changes to long_base, short_base or win_size during a window have no effect until the next window start.
- R8: With interlaced=1 the captured base alternates between long_base and short_base on successive windows. The first field uses long_base after reset or after any window with interlaced=0. With interlaced=0 long_base is always used.
- R9: A line start that arrives while a line is being fetched is ignored. A window start aborts any fetch, so fetch_valid is 0 after the next edge, and it restarts the window.
- R10: When a window start and a line start are sampled at the same edge, the line start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start | input | 1 | Display-window start strobe (vertical retrace) |
| line_start | input | 1 | Visible line start strobe |
| interlaced | input | 1 | Field-alternating mode select |
| long_base | input | ADDR_W | Word address of the long (first) field |
| short_base | input | ADDR_W | Word address of the short (second) field |
| win_size | input | 3*CNT_W | Packed modulo, line count minus one, width minus one |
| fetch_valid | output | 1 | An address is presented this cycle |
| fetch_addr | output | ADDR_W | Word address to fetch |

## Verification
The hardest situations to reach are the ones where strobes collide with an active fetch. These are a line start arriving mid-line, a window start cutting a line short, and both strobes landing at the same edge. The bench reaches them with directed sequences that raise the second strobe at a chosen word of a line. It then checks that the word count and the next line start are not disturbed, or that the new window begins at its own base. Field alternation is checked by running two interlaced windows back to back, then a progressive one, then an interlaced one again, and comparing each first address with a field model kept in the bench.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FETCH = 2'd2
    } walk_state_t;
endpackage

// File: rtl/scan_size_unpack.sv
module scan_size_unpack #(
    parameter int CNT_W = 10
) (
    input  logic [3*CNT_W-1:0] size_word,
    output logic [CNT_W-1:0]   width_last,
    output logic [CNT_W-1:0]   height_last,
    output logic [CNT_W-1:0]   modulo
);
    localparam int NFLD = 3;
    logic [CNT_W-1:0] fld [NFLD];

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        assign fld[f] = size_word[f*CNT_W +: CNT_W];
    end

    assign width_last  = fld[0];
    assign height_last = fld[1];
    assign modulo      = fld[2];
endmodule

// File: rtl/scan_shadow.sv
module scan_shadow #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_start,
    input  logic              interlaced,
    input  logic [ADDR_W-1:0] long_base,
    input  logic [ADDR_W-1:0] short_base,
    input  logic [CNT_W-1:0]  width_in,
    input  logic [CNT_W-1:0]  height_in,
    input  logic [CNT_W-1:0]  mod_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  width_q,
    output logic [CNT_W-1:0]  height_q,
    output logic [CNT_W-1:0]  mod_q,
    output logic              short_sel_q
);
    logic field_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            width_q     <= '0;
            height_q    <= '0;
            mod_q       <= '0;
            short_sel_q <= 1'b0;
            field_nxt   <= 1'b0;
        end else if (win_start) begin
            base_q      <= (interlaced && field_nxt) ? short_base : long_base;
            short_sel_q <= interlaced && field_nxt;
            field_nxt   <= interlaced ? ~field_nxt : 1'b0;
            width_q     <= width_in;
            height_q    <= height_in;
            mod_q       <= mod_in;
        end
    end

    // R7
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_start |=> ($stable(base_q) && $stable(width_q) && $stable(mod_q)));

    // R8
    flat_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start && !interlaced) |=> !short_sel_q);
endmodule

// File: rtl/scan_walker.sv
module scan_walker
    import scan_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_start,
    input  logic              line_start,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  width_last,
    input  logic [CNT_W-1:0]  height_last,
    input  logic [CNT_W-1:0]  modulo,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr
);
    walk_state_t       state, nstate;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] next_line;
    logic [CNT_W-1:0]  wcnt;
    logic [CNT_W-1:0]  lcnt;
    logic              line_end;

    assign line_end = (wcnt == width_last);

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  nstate = win_start ? ST_WAIT : ST_IDLE;
            ST_WAIT:  nstate = win_start ? ST_WAIT :
                               (line_start ? ST_FETCH : ST_WAIT);
            ST_FETCH: begin
                if (win_start)
                    nstate = ST_WAIT;
                else if (line_end)
                    nstate = (lcnt == height_last) ? ST_IDLE : ST_WAIT;
                else
                    nstate = ST_FETCH;
            end
            default:  nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            next_line <= '0;
            wcnt      <= '0;
            lcnt      <= '0;
        end else if (win_start) begin
            wcnt <= '0;
            lcnt <= '0;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (line_start) begin
                        cur_addr <= (lcnt == '0) ? base : next_line;
                        wcnt     <= '0;
                    end
                end
                ST_FETCH: begin
                    if (line_end) begin
                        next_line <= cur_addr + ADDR_W'(modulo);
                        lcnt      <= lcnt + CNT_W'(1);
                    end else begin
                        cur_addr <= cur_addr + ADDR_W'(1);
                        wcnt     <= wcnt + CNT_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        fetch_valid = (state == ST_FETCH);
        fetch_addr  = cur_addr;
    end

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !win_start && !line_end) |=>
            (fetch_valid && fetch_addr == $past(fetch_addr) + ADDR_W'(1)));

    // R9
    win_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> !fetch_valid);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !win_start) |=> !fetch_valid);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (wcnt <= width_last));
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_start,
    input  logic               line_start,
    input  logic               interlaced,
    input  logic [ADDR_W-1:0]  long_base,
    input  logic [ADDR_W-1:0]  short_base,
    input  logic [3*CNT_W-1:0] win_size,
    output logic               fetch_valid,
    output logic [ADDR_W-1:0]  fetch_addr
);
    logic [CNT_W-1:0]  w_in, h_in, m_in;
    logic [CNT_W-1:0]  w_q, h_q, m_q;
    logic [ADDR_W-1:0] base_q;
    logic              short_sel;

    scan_size_unpack #(.CNT_W(CNT_W)) u_unpack (
        .size_word   (win_size),
        .width_last  (w_in),
        .height_last (h_in),
        .modulo      (m_in)
    );

    scan_shadow #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_start   (win_start),
        .interlaced  (interlaced),
        .long_base   (long_base),
        .short_base  (short_base),
        .width_in    (w_in),
        .height_in   (h_in),
        .mod_in      (m_in),
        .base_q      (base_q),
        .width_q     (w_q),
        .height_q    (h_q),
        .mod_q       (m_q),
        .short_sel_q (short_sel)
    );

    scan_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_start   (win_start),
        .line_start  (line_start),
        .base        (base_q),
        .width_last  (w_q),
        .height_last (h_q),
        .modulo      (m_q),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !fetch_valid);

    // R8
    field_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start && interlaced && short_sel) |=> !short_sel);
endmodule

// File: tb/scan_addr_gen_test.sv
`timescale 1ns/1ps
module scan_addr_gen_test;
    localparam int AW = 24;
    localparam int CW = 10;
    localparam int NV = 4;

    localparam logic [AW-1:0] V_LB  [NV] = '{24'h000100, 24'h010000, 24'h010000, 24'h0ABC00};
    localparam logic [AW-1:0] V_SB  [NV] = '{24'h000900, 24'h010010, 24'h010010, 24'h0FF000};
    localparam int            V_WL  [NV] = '{3, 15, 15, 0};
    localparam int            V_HL  [NV] = '{2, 3, 3, 0};
    localparam int            V_MOD [NV] = '{1, 17, 17, 5};
    localparam bit            V_INT [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_start = 1'b0;
    logic line_start = 1'b0;
    logic interlaced = 1'b0;
    logic [AW-1:0] long_base = '0;
    logic [AW-1:0] short_base = '0;
    logic [3*CW-1:0] win_size = '0;
    logic fetch_valid;
    logic [AW-1:0] fetch_addr;

    int checks = 0;
    int failures = 0;
    bit fnext = 1'b0;
    logic [AW-1:0] exp_base;
    logic [AW-1:0] run_addr;

    always #10 clk = ~clk;

    scan_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .line_start(line_start),
        .interlaced(interlaced), .long_base(long_base), .short_base(short_base),
        .win_size(win_size), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr)
    );

    function automatic logic [3*CW-1:0] pack(int wl, int hl, int md);
        return {CW'(md), CW'(hl), CW'(wl)};
    endfunction

    task automatic chk(input string req, input bit ok, input logic [AW:0] act, input logic [AW:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, fetch_valid == 1'b0, {fetch_valid, fetch_addr}, '0);
    endtask

    task automatic start_win(input logic [AW-1:0] lb, input logic [AW-1:0] sb,
                             input int wl, input int hl, input int md,
                             input bit il, input bit with_line);
        @(negedge clk);
        long_base  = lb;
        short_base = sb;
        win_size   = pack(wl, hl, md);
        interlaced = il;
        win_start  = 1'b1;
        line_start = with_line;
        exp_base   = (il && fnext) ? sb : lb;
        fnext      = il ? ~fnext : 1'b0;
        @(negedge clk);
        win_start  = 1'b0;
        line_start = 1'b0;
    endtask

    task automatic do_line(input logic [AW-1:0] start, input int wl, input string first_req);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int w = 0; w <= wl; w++) begin
            chk((w == 0) ? first_req : "R3", fetch_valid && fetch_addr == start + AW'(w),
                {fetch_valid, fetch_addr}, {1'b1, start + AW'(w)});
            @(negedge clk);
        end
        chk_idle("R2");
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state and quiet idle after reset
        repeat (3) begin
            @(negedge clk);
            line_start = 1'b1;
            chk_idle("R1");
        end
        @(negedge clk);
        line_start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk_idle("R1");
        @(negedge clk);
        chk_idle("R1");

        // Vector table: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            start_win(V_LB[v], V_SB[v], V_WL[v], V_HL[v], V_MOD[v], V_INT[v], 1'b0);
            if (v == 2)
                chk("R8", exp_base == V_SB[v], {1'b0, exp_base}, {1'b0, V_SB[v]});
            for (int l = 0; l <= V_HL[v]; l++)
                do_line(exp_base + AW'(l * (V_WL[v] + V_MOD[v])), V_WL[v], (l == 0) ? "R5" : "R4");
            // R6: surplus line start after the last line
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            for (int k = 0; k < V_WL[v] + 2; k++) begin
                chk_idle("R6");
                @(negedge clk);
            end
        end

        // R8: after a progressive window, interlaced restarts on the long base
        start_win(24'h020000, 24'h020008, 7, 0, 9, 1'b1, 1'b0);
        do_line(24'h020000, 7, "R8");
        start_win(24'h020000, 24'h020008, 7, 0, 9, 1'b1, 1'b0);
        do_line(24'h020008, 7, "R8");

        // R7: programming changed mid-window is not used
        start_win(24'h200000, 24'h0, 2, 1, 1, 1'b0, 1'b0);
        long_base = 24'h300000;
        win_size  = pack(9, 5, 40);
        do_line(24'h200000, 2, "R7");
        do_line(24'h200003, 2, "R7");
        chk_idle("R7");

        // R9: line start during a fetch is ignored
        start_win(24'h004000, 24'h0, 3, 1, 2, 1'b0, 1'b0);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        run_addr = 24'h004000;
        for (int w = 0; w <= 3; w++) begin
            line_start = (w == 1);
            chk("R9", fetch_valid && fetch_addr == run_addr + AW'(w),
                {fetch_valid, fetch_addr}, {1'b1, run_addr + AW'(w)});
            @(negedge clk);
        end
        line_start = 1'b0;
        chk_idle("R9");
        do_line(24'h004005, 3, "R9");

        // R9: window start aborts a fetch
        start_win(24'h005000, 24'h0, 7, 3, 1, 1'b0, 1'b0);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        @(negedge clk);
        start_win(24'h006000, 24'h0, 1, 0, 1, 1'b0, 1'b0);
        chk_idle("R9");
        do_line(24'h006000, 1, "R9");

        // R10: coincident window and line starts
        start_win(24'h007000, 24'h0, 1, 0, 1, 1'b0, 1'b1);
        chk_idle("R10");
        @(negedge clk);
        chk_idle("R10");
        do_line(24'h007000, 1, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule